// File: doc/BRIEF.md
# Channel Input Sample Qualifier

This block sits at the head of a receive channel. Two input ports each present a 14-bit mantissa, a 3-bit exponent and an enable line. The block picks one port and, under a 2-bit enable mode, decides on which clock cycles a sample enters the channel. It issues a one-cycle valid strobe with the captured sample. In bypass it instead forwards port A on an I lane and port B on a Q lane, so that a real filter can run on baseband I/Q data without frequency translation.

The channel has no way to refuse a sample, so the output stream carries a valid strobe and no ready. Downstream logic must accept every beat on the cycle it is flagged. Between beats the output registers hold their last captured value. Mode, port select and bypass are plain level controls and take effect on the next clock edge.

Top module: `chan_sample_qualifier`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and every data output is 0.
- R2: When `cfg_port_sel` is 0, port A supplies the sample on `out_mant`/`out_exp`. When it is 1, port B supplies it.
- R3: With `cfg_mode` = 0 (every-clock mode), `out_valid` is 1 on every cycle after reset. The sample is the one present at the previous clock edge.
- R4: In mode 0, if the selected enable is low at the capturing edge, the beat still occurs but all captured data is zero. Outside bypass this is mantissa and exponent. In bypass it is both lanes.
- R5: With `cfg_mode` = 1 (gate mode), a beat occurs exactly on the edges where the selected enable is high. An enable that toggles every clock therefore gives one beat every two cycles.
- R6: With `cfg_mode` = 2 (rise mode), a beat occurs on an edge where the selected enable is high and was low at the previous edge. Enable history is cleared by reset, so an enable that is high on the first edge after reset counts as a rise.
- R7: With `cfg_mode` = 3 (fall mode), a beat occurs on an edge where the selected enable is low and was high at the previous edge.
- R8: Each port keeps its own enable history whether or not it is selected. After a change of `cfg_port_sel`, edge detection compares the newly selected enable with that same port's own previous value.
- R9: With `cfg_bypass` = 1, a beat loads `out_i_*` from port A and `out_q_*` from port B and loads zero into `out_mant`/`out_exp`. The beat timing follows R3 to R7 applied to the selected port's enable. Without bypass, a beat loads zero into both lanes.
- R10: All data outputs change only on a beat, one clock after the capturing edge. Otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_mant | input | 14 | Port A mantissa |
| a_exp | input | 3 | Port A exponent |
| a_en | input | 1 | Port A enable |
| b_mant | input | 14 | Port B mantissa |
| b_exp | input | 3 | Port B exponent |
| b_en | input | 1 | Port B enable |
| cfg_mode | input | 2 | Enable mode: 0 every clock, 1 gate, 2 rise, 3 fall |
| cfg_port_sel | input | 1 | 0 selects port A, 1 selects port B |
| cfg_bypass | input | 1 | 1 forwards A to I lane and B to Q lane |
| out_valid | output | 1 | Beat strobe |
| out_mant | output | 14 | Captured mantissa (normal path) |
| out_exp | output | 3 | Captured exponent (normal path) |
| out_i_mant | output | 14 | I lane mantissa (bypass) |
| out_i_exp | output | 3 | I lane exponent (bypass) |
| out_q_mant | output | 14 | Q lane mantissa (bypass) |
| out_q_exp | output | 3 | Q lane exponent (bypass) |

## Verification
A corrupted enable history shows up on the very next beat decision in rise or fall mode, as a missing or extra strobe one cycle after the edge. A history shared between ports appears only after a port-select change, on the first edge that compares across ports. A wrong mask or lane choice appears on the data outputs in the cycle of the affected beat. Because outputs hold between beats, it then persists until the next beat.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    SQ_EVERY = 2'd0,
    SQ_GATE  = 2'd1,
    SQ_RISE  = 2'd2,
    SQ_FALL  = 2'd3
  } sq_mode_e;
endpackage

// File: rtl/sq_en_hist.sv
// Holds the enable seen at the previous clock edge for one port.
module sq_en_hist (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  output logic en_prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= en_in;
  end
endmodule

// File: rtl/sq_qualify.sv
// Turns the current and previous enable into a beat decision and a mask.
module sq_qualify
  import sq_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       en_now,
  input  logic       en_prev,
  output logic       take,
  output logic       zero
);
  sq_mode_e m;
  always_comb begin
    m    = sq_mode_e'(mode);
    zero = 1'b0;
    unique case (m)
      SQ_EVERY: begin take = 1'b1; zero = ~en_now; end
      SQ_GATE:  take = en_now;
      SQ_RISE:  take = en_now & ~en_prev;
      SQ_FALL:  take = ~en_now & en_prev;
      default:  take = 1'b0;
    endcase
  end
endmodule

// File: rtl/sq_capture.sv
// Load-enabled holding register for the output bundle.
module sq_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/chan_sample_qualifier.sv
module chan_sample_qualifier #(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic              a_en,
  input  logic [MANT_W-1:0] b_mant,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic              b_en,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_port_sel,
  input  logic              cfg_bypass,
  output logic              out_valid,
  output logic [MANT_W-1:0] out_mant,
  output logic [EXP_W-1:0]  out_exp,
  output logic [MANT_W-1:0] out_i_mant,
  output logic [EXP_W-1:0]  out_i_exp,
  output logic [MANT_W-1:0] out_q_mant,
  output logic [EXP_W-1:0]  out_q_exp
);
  localparam int NPORT = 2;
  localparam int SMP_W = MANT_W + EXP_W;
  localparam int BUN_W = 3 * SMP_W;

  logic [NPORT-1:0] en_vec;
  logic [NPORT-1:0] en_prev_vec;
  logic [SMP_W-1:0] smp_vec [NPORT];

  assign en_vec     = {b_en, a_en};
  assign smp_vec[0] = {a_mant, a_exp};
  assign smp_vec[1] = {b_mant, b_exp};

  // one enable history per port, kept regardless of selection
  for (genvar p = 0; p < NPORT; p++) begin : g_hist
    sq_en_hist u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_in  (en_vec[p]),
      .en_prev(en_prev_vec[p])
    );
  end

  logic sel_en, sel_prev, take, zero;
  assign sel_en   = en_vec[cfg_port_sel];
  assign sel_prev = en_prev_vec[cfg_port_sel];

  sq_qualify u_qual (
    .mode   (cfg_mode),
    .en_now (sel_en),
    .en_prev(sel_prev),
    .take   (take),
    .zero   (zero)
  );

  logic [SMP_W-1:0] main_nxt, i_nxt, q_nxt;
  always_comb begin
    main_nxt = (cfg_bypass || zero) ? '0 : smp_vec[cfg_port_sel];
    i_nxt    = (!cfg_bypass || zero) ? '0 : smp_vec[0];
    q_nxt    = (!cfg_bypass || zero) ? '0 : smp_vec[1];
  end

  logic [BUN_W-1:0] bundle_q;
  sq_capture #(.W(BUN_W)) u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .load (take),
    .d    ({main_nxt, i_nxt, q_nxt}),
    .q    (bundle_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= take;
  end

  assign {out_mant, out_exp, out_i_mant, out_i_exp, out_q_mant, out_q_exp} = bundle_q;
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MANT_W-1:0] a_mant,
  input logic              a_en,
  input logic [MANT_W-1:0] b_mant,
  input logic              b_en,
  input logic [1:0]        cfg_mode,
  input logic              cfg_port_sel,
  input logic              cfg_bypass,
  input logic              out_valid,
  input logic [MANT_W-1:0] out_mant,
  input logic [EXP_W-1:0]  out_exp,
  input logic [MANT_W-1:0] out_i_mant,
  input logic [MANT_W-1:0] out_q_mant
);
  logic sel_en;
  assign sel_en = cfg_port_sel ? b_en : a_en;

  // R3
  every_clock_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_mode) == 2'd0) |-> out_valid);

  // R4
  masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_mode) == 2'd0 && !$past(sel_en) && !$past(cfg_bypass))
      |-> (out_mant == '0 && out_exp == '0));

  // R5
  gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_mode) == 2'd1) |-> (out_valid == $past(sel_en)));

  // R6
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(cfg_mode) == 2'd2 && !$past(cfg_port_sel) && out_valid)
      |-> ($past(a_en) && !$past(a_en, 2)));

  // R7
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(cfg_mode) == 2'd3 && $past(cfg_port_sel) && out_valid)
      |-> (!$past(b_en) && $past(b_en, 2)));

  // R9
  bypass_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_bypass) && $past(cfg_mode) != 2'd0 && out_valid)
      |-> (out_i_mant == $past(a_mant) && out_q_mant == $past(b_mant) && out_mant == '0));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !out_valid) |-> ($stable(out_mant) && $stable(out_i_mant) && $stable(out_q_mant)));
endmodule

bind chan_sample_qualifier sq_checker #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_sq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .a_mant      (a_mant),
  .a_en        (a_en),
  .b_mant      (b_mant),
  .b_en        (b_en),
  .cfg_mode    (cfg_mode),
  .cfg_port_sel(cfg_port_sel),
  .cfg_bypass  (cfg_bypass),
  .out_valid   (out_valid),
  .out_mant    (out_mant),
  .out_exp     (out_exp),
  .out_i_mant  (out_i_mant),
  .out_q_mant  (out_q_mant)
);

// File: tb/tb_chan_sample_qualifier.sv
`timescale 1ns/1ps
module tb_chan_sample_qualifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] a_mant = '0, b_mant = '0;
  logic [2:0]  a_exp = '0, b_exp = '0;
  logic a_en = 1'b0, b_en = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_port_sel = 1'b0, cfg_bypass = 1'b0;
  logic out_valid;
  logic [13:0] out_mant, out_i_mant, out_q_mant;
  logic [2:0]  out_exp, out_i_exp, out_q_exp;

  always #2 clk = ~clk;

  chan_sample_qualifier dut (
    .clk(clk), .rst_n(rst_n),
    .a_mant(a_mant), .a_exp(a_exp), .a_en(a_en),
    .b_mant(b_mant), .b_exp(b_exp), .b_en(b_en),
    .cfg_mode(cfg_mode), .cfg_port_sel(cfg_port_sel), .cfg_bypass(cfg_bypass),
    .out_valid(out_valid), .out_mant(out_mant), .out_exp(out_exp),
    .out_i_mant(out_i_mant), .out_i_exp(out_i_exp),
    .out_q_mant(out_q_mant), .out_q_exp(out_q_exp)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic m_prev_a, m_prev_b, m_valid;
  logic [50:0] m_bundle;
  string m_tag, dir_tag = "";

  function automatic logic [50:0] act_bundle();
    return {out_mant, out_exp, out_i_mant, out_i_exp, out_q_mant, out_q_exp};
  endfunction

  function automatic string mode_tag(logic [1:0] m, logic z, logic byp, logic tk);
    if (!tk) return "R10";
    if (byp) return "R9";
    case (m)
      2'd0: return z ? "R4" : "R3";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [51:0] act, logic [51:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic model_reset();
    m_prev_a = 0; m_prev_b = 0; m_valid = 0; m_bundle = '0; m_tag = "R1";
  endtask

  // model of the edge about to come, from the inputs now driven
  task automatic model_step();
    logic se, sp, tk, z;
    logic [16:0] sa, sb;
    se = cfg_port_sel ? b_en : a_en;
    sp = cfg_port_sel ? m_prev_b : m_prev_a;
    case (cfg_mode)
      2'd0: tk = 1;
      2'd1: tk = se;
      2'd2: tk = se & ~sp;
      default: tk = ~se & sp;
    endcase
    z = (cfg_mode == 2'd0) && !se;
    sa = {a_mant, a_exp}; sb = {b_mant, b_exp};
    if (tk) begin
      if (z) m_bundle = '0;
      else if (cfg_bypass) m_bundle = {17'd0, sa, sb};
      else m_bundle = {(cfg_port_sel ? sb : sa), 34'd0};
    end
    m_valid = tk;
    m_tag = (dir_tag != "") ? dir_tag : mode_tag(cfg_mode, z, cfg_bypass, tk);
    if (!cfg_bypass && tk && !z) m_tag = {m_tag, "/R2"};
    m_prev_a = a_en; m_prev_b = b_en;
  endtask

  // compare previous edge result, then let the model see the next edge
  task automatic cycle();
    @(negedge clk);
    check(m_tag, {out_valid, act_bundle()}, {m_valid, m_bundle});
  endtask

  task automatic drive(logic [1:0] m, logic sel, logic byp, logic ae, logic be);
    cfg_mode = m; cfg_port_sel = sel; cfg_bypass = byp;
    a_en = ae; b_en = be;
    a_mant = 14'($urandom); b_mant = 14'($urandom);
    a_exp = 3'($urandom); b_exp = 3'($urandom);
    model_step();
    cycle();
  endtask

  task automatic do_reset();
    rst_n = 0; a_en = 0; b_en = 0;
    model_reset();
    @(negedge clk);
    check("R1", {out_valid, act_bundle()}, 52'd0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int beats;
    void'($urandom(32'h5a17));
    model_reset();
    do_reset();

    // R6: enable high on first edge after reset is a rise
    dir_tag = "R6";
    drive(2'd2, 0, 0, 1, 0);
    drive(2'd2, 0, 0, 1, 0);
    dir_tag = "";

    // R5: toggling enable yields half rate
    do_reset();
    beats = 0;
    for (int k = 0; k < 20; k++) begin
      drive(2'd1, 0, 0, k[0], 0);
      beats += out_valid;
    end
    check("R5", 52'(beats), 52'd10);

    // R8: B rises while A is selected; selecting B later sees no rise
    do_reset();
    dir_tag = "R8";
    drive(2'd2, 0, 0, 0, 0);
    drive(2'd2, 0, 0, 0, 1);
    drive(2'd2, 1, 0, 0, 1);
    drive(2'd2, 1, 0, 0, 0);
    drive(2'd3, 0, 0, 1, 0);
    drive(2'd3, 1, 0, 0, 0);
    dir_tag = "";

    // R4 with bypass: masked beat zeroes both lanes
    drive(2'd0, 0, 1, 1, 1);
    drive(2'd0, 0, 1, 0, 1);

    // R1 again mid-run
    do_reset();

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [1:0] m; logic s, b;
      m = cfg_mode; s = cfg_port_sel; b = cfg_bypass;
      if ($urandom_range(0, 39) == 0) begin
        m = 2'($urandom); s = 1'($urandom); b = ($urandom_range(0, 3) == 0);
      end
      drive(m, s, b, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule